// File: doc/BRIEF.md
# External Trigger Conditioner

This block takes a raw, asynchronous trigger pin meant for a timer and turns it into a clean level in the timer clock domain. The pin first crosses a two-flop synchronizer. A prescaler then divides its rate of rising edges by 1, 2, 4 or 8, so that a fast trigger can be slowed to a rate the timer clock can sample reliably. The divided signal then enters a digital glitch filter. The filter's output level changes only after a set number of consecutive samples disagree with it.

A 4-bit filter code selects two things at once: the rate at which the filter samples, and the run length N it needs. The sampling rate is derived either from every timer clock or from a free-running divider of a dead-time clock enable. Downstream logic uses the filtered level, or the one-cycle pulse that marks each rising transition of that level, as its trigger.

Top module: `trig_conditioner`

## Requirements
- R1: While reset is asserted and just after it is released, `trig_lvl` and `trig_rise` are 0.
- R2: With filter code 0, prescaler select 0 and `dts_en` held high, `trig_lvl` takes a new stable pin level on the third rising clock edge after the pin changes (two synchronizer stages plus one filter register).
- R3: Prescaler select 0, 1, 2 and 3 give one rising transition of the filter input for every 1, 2, 4 and 8 rising pin edges. For selects 1 to 3 the prescaled signal is a square wave that toggles every 1, 2 and 4 pin edges.
- R4: The filter flips `trig_lvl` only once N consecutive samples differ from it. A sample equal to `trig_lvl` restarts the count, so a disagreement shorter than N samples leaves the output unchanged.
- R5: Codes 1, 2 and 3 sample on every timer clock regardless of `dts_en`, with N equal to 2, 4 and 8. A pin step is seen at `trig_lvl` exactly 2+N clock edges later.
- R6: Codes 4 to 15 sample once every D pulses of `dts_en`, with (D,N) per code: 4:(2,6) 5:(2,8) 6:(4,6) 7:(4,8) 8:(8,6) 9:(8,8) 10:(16,5) 11:(16,6) 12:(16,8) 13:(32,5) 14:(32,6) 15:(32,8). With `dts_en` always high, a pin step appears after between 3+(N-1)·D and 2+N·D clock edges.
- R7: Code 0 samples only in cycles where `dts_en` is high, with N=1. While `dts_en` stays low under code 0, `trig_lvl` does not change.
- R8: In a cycle where `flt_code` or `psc_sel` differs from its value in the previous cycle, the filter run count, the prescaler edge count and the sample divider all clear, and `trig_lvl` keeps its value.
- R9: `trig_rise` is high for exactly the first cycle in which `trig_lvl` is 1 after being 0, and is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| dts_en | input | 1 | Dead-time reference clock enable, one cycle per reference tick |
| trig_raw | input | 1 | Asynchronous trigger pin |
| psc_sel | input | 2 | Edge prescaler select: divide by 1, 2, 4, 8 |
| flt_code | input | 4 | Filter code choosing sampling divisor and run length |
| trig_lvl | output | 1 | Filtered trigger level |
| trig_rise | output | 1 | One-cycle pulse on each 0-to-1 transition of trig_lvl |

## Verification
The bound checker watches on every cycle that the run count stays below N outside configuration changes, that the level holds through a configuration change, that code 0 cannot move the level without `dts_en`, and that the rising pulse lasts one cycle and goes with each rise of the level. Only the bench's scenarios can show the actual latencies for each filter code, the divide ratios of the prescaler, the rejection of glitches one sample short of N, and the clearing of partly filled counts when the configuration changes. These are measured as edge counts and compared against arithmetic windows.

// File: rtl/trig_conditioner.sv
module trig_conditioner #(
  parameter int RUN_W = 4,
  parameter int DIV_W = 5,
  parameter int PSC_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dts_en,
  input  logic       trig_raw,
  input  logic [1:0] psc_sel,
  input  logic [3:0] flt_code,
  output logic       trig_lvl,
  output logic       trig_rise
);

  logic             sync_a, sync_b, sync_b_d;
  logic [1:0]       psc_q;
  logic [3:0]       code_q;
  logic             cfg_chg;
  logic [PSC_W-1:0] psc_cnt, psc_last;
  logic             psc_out;
  logic             pre_sig;
  logic [DIV_W-1:0] div_cnt, div_lim;
  logic [RUN_W-1:0] run_cnt, run_n;
  logic             fast, strobe;
  logic             lvl_q, lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a   <= 1'b0;
      sync_b   <= 1'b0;
      sync_b_d <= 1'b0;
      psc_q    <= '0;
      code_q   <= '0;
    end else begin
      sync_a   <= trig_raw;
      sync_b   <= sync_a;
      sync_b_d <= sync_b;
      psc_q    <= psc_sel;
      code_q   <= flt_code;
    end
  end

  assign cfg_chg = (psc_sel != psc_q) || (flt_code != code_q);

  always_comb begin
    case (psc_sel)
      2'd2:    psc_last = PSC_W'(1);
      2'd3:    psc_last = PSC_W'(3);
      default: psc_last = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_cnt <= '0;
      psc_out <= 1'b0;
    end else if (cfg_chg) begin
      psc_cnt <= '0;
    end else if (psc_sel != 2'd0 && sync_b && !sync_b_d) begin
      if (psc_cnt == psc_last) begin
        psc_cnt <= '0;
        psc_out <= ~psc_out;
      end else begin
        psc_cnt <= psc_cnt + 1'b1;
      end
    end
  end

  assign pre_sig = (psc_sel == 2'd0) ? sync_b : psc_out;

  always_comb begin
    div_lim = '0;
    run_n   = RUN_W'(8);
    case (flt_code)
      4'd0:  run_n = RUN_W'(1);
      4'd1:  run_n = RUN_W'(2);
      4'd2:  run_n = RUN_W'(4);
      4'd3:  run_n = RUN_W'(8);
      4'd4:  begin div_lim = DIV_W'(1);  run_n = RUN_W'(6); end
      4'd5:  begin div_lim = DIV_W'(1);  run_n = RUN_W'(8); end
      4'd6:  begin div_lim = DIV_W'(3);  run_n = RUN_W'(6); end
      4'd7:  begin div_lim = DIV_W'(3);  run_n = RUN_W'(8); end
      4'd8:  begin div_lim = DIV_W'(7);  run_n = RUN_W'(6); end
      4'd9:  begin div_lim = DIV_W'(7);  run_n = RUN_W'(8); end
      4'd10: begin div_lim = DIV_W'(15); run_n = RUN_W'(5); end
      4'd11: begin div_lim = DIV_W'(15); run_n = RUN_W'(6); end
      4'd12: begin div_lim = DIV_W'(15); run_n = RUN_W'(8); end
      4'd13: begin div_lim = DIV_W'(31); run_n = RUN_W'(5); end
      4'd14: begin div_lim = DIV_W'(31); run_n = RUN_W'(6); end
      default: begin div_lim = DIV_W'(31); run_n = RUN_W'(8); end
    endcase
  end

  assign fast   = (flt_code != 4'd0) && (flt_code < 4'd4);
  assign strobe = fast || (dts_en && div_cnt == div_lim);

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_chg)
      div_cnt <= '0;
    else if (dts_en)
      div_cnt <= (div_cnt == div_lim) ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      lvl_q   <= 1'b0;
    end else if (cfg_chg) begin
      run_cnt <= '0;
    end else if (strobe) begin
      if (pre_sig == lvl_q) begin
        run_cnt <= '0;
      end else if ({1'b0, run_cnt} + 1'b1 >= {1'b0, run_n}) begin
        run_cnt <= '0;
        lvl_q   <= ~lvl_q;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl_q;
  end

  assign trig_lvl  = lvl_q;
  assign trig_rise = lvl_q & ~lvl_d;

endmodule

module trig_conditioner_chk #(
  parameter int RUN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dts_en,
  input logic [1:0]       psc_sel,
  input logic [3:0]       flt_code,
  input logic             trig_lvl,
  input logic             trig_rise,
  input logic             cfg_chg,
  input logic [RUN_W-1:0] run_cnt,
  input logic [RUN_W-1:0] run_n
);

  AST_RUN_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> run_cnt < run_n); // R4

  AST_HOLD_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_code != $past(flt_code) || psc_sel != $past(psc_sel)) |=> $stable(trig_lvl)); // R8

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_code == 4'd0 && !dts_en) |=> $stable(trig_lvl)); // R7

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise); // R9

  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_lvl) |-> trig_rise); // R9

endmodule

bind trig_conditioner trig_conditioner_chk #(.RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dts_en(dts_en), .psc_sel(psc_sel),
  .flt_code(flt_code), .trig_lvl(trig_lvl), .trig_rise(trig_rise),
  .cfg_chg(cfg_chg), .run_cnt(run_cnt), .run_n(run_n)
);

// File: tb/test_trig_conditioner.sv
`timescale 1ns/1ps
module test_trig_conditioner;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dts_en = 1'b1;
  logic       trig_raw = 1'b0;
  logic [1:0] psc_sel = 2'd0;
  logic [3:0] flt_code = 4'd0;
  logic       trig_lvl, trig_rise;

  int n_chk = 0;
  int n_bad = 0;
  int rises_seen = 0;
  int lvl_rises = 0;
  int wide_pulses = 0;
  logic prev_lvl = 1'b0;
  logic prev_rise = 1'b0;

  always #5 clk = ~clk;

  trig_conditioner i_trig_conditioner (
    .clk(clk), .rst_n(rst_n), .dts_en(dts_en), .trig_raw(trig_raw),
    .psc_sel(psc_sel), .flt_code(flt_code),
    .trig_lvl(trig_lvl), .trig_rise(trig_rise)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (trig_rise) rises_seen++;
      if (trig_lvl && !prev_lvl) lvl_rises++;
      if (trig_rise && prev_rise) wide_pulses++;
    end
    prev_lvl  = trig_lvl;
    prev_rise = trig_rise;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int n_of(input int c);
    case (c)
      0: return 1;  1: return 2;  2: return 4;  3: return 8;
      4, 6, 8, 11, 14: return 6;
      10, 13: return 5;
      default: return 8;
    endcase
  endfunction

  function automatic int d_of(input int c);
    if (c < 4) return 1;
    if (c < 6) return 2;
    if (c < 8) return 4;
    if (c < 10) return 8;
    if (c < 13) return 16;
    return 32;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(input logic v, output int lat);
    @(negedge clk);
    trig_raw = v;
    lat = 0;
    while (trig_lvl !== v && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic pulse();
    @(negedge clk);
    trig_raw = 1'b1;
    cyc(3);
    trig_raw = 1'b0;
    cyc(3);
  endtask

  initial begin
    #(2_000_000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, base, k;
    logic l0;

    cyc(4);
    check(trig_lvl == 1'b0 && trig_rise == 1'b0, "R1 in reset", trig_lvl, 0);
    rst_n = 1'b1;
    cyc(2);
    check(trig_lvl == 1'b0 && trig_rise == 1'b0, "R1 after reset", trig_lvl, 0);

    // R2: pass-through latency
    step(1'b1, lat); check(lat == 3, "R2 rise latency", lat, 3);
    step(1'b0, lat); check(lat == 3, "R2 fall latency", lat, 3);

    // R5: timer-rate codes ignore dts_en
    dts_en = 1'b0;
    for (int c = 1; c < 4; c++) begin
      flt_code = 4'(c);
      cyc(20);
      step(1'b1, lat); check(lat == 2 + n_of(c), "R5 rise", lat, 2 + n_of(c));
      step(1'b0, lat); check(lat == 2 + n_of(c), "R5 fall", lat, 2 + n_of(c));
    end
    dts_en = 1'b1;

    // R6: divided sampling codes
    for (int c = 4; c < 16; c++) begin
      int lo, hi;
      flt_code = 4'(c);
      cyc(40);
      lo = 3 + (n_of(c) - 1) * d_of(c);
      hi = 2 + n_of(c) * d_of(c);
      step(1'b1, lat); check(lat >= lo && lat <= hi, "R6 rise", lat, hi);
      step(1'b0, lat); check(lat >= lo && lat <= hi, "R6 fall", lat, hi);
    end

    // R7: code 0 needs dts_en
    flt_code = 4'd0;
    cyc(10);
    dts_en = 1'b0;
    trig_raw = 1'b1;
    cyc(40);
    check(trig_lvl == 1'b0, "R7 held without dts_en", trig_lvl, 0);
    dts_en = 1'b1;
    cyc(3);
    check(trig_lvl == 1'b1, "R7 moves with dts_en", trig_lvl, 1);
    trig_raw = 1'b0;
    cyc(10);

    // R4: glitch one sample short of N is rejected
    flt_code = 4'd3;
    cyc(20);
    base = rises_seen;
    trig_raw = 1'b1; cyc(7); trig_raw = 1'b0;
    cyc(20);
    check(trig_lvl == 1'b0 && rises_seen == base, "R4 short glitch", rises_seen - base, 0);
    trig_raw = 1'b1; cyc(8); trig_raw = 1'b0;
    cyc(30);
    check(rises_seen == base + 1, "R4 full run", rises_seen - base, 1);

    // R3: prescaler ratios
    flt_code = 4'd0;
    for (int p = 0; p < 4; p++) begin
      psc_sel = 2'(p);
      cyc(20);
      base = rises_seen;
      for (int i = 0; i < 16; i++) pulse();
      cyc(10);
      check(rises_seen - base == (16 >> p), "R3 divide", rises_seen - base, 16 >> p);
    end

    // R8: run count clears on code change, level held
    psc_sel = 2'd0;
    flt_code = 4'd3;
    cyc(20);
    @(negedge clk); trig_raw = 1'b1;
    cyc(7);
    flt_code = 4'd2;
    lat = 0;
    while (trig_lvl !== 1'b1 && lat < 100) begin
      @(negedge clk);
      lat++;
      if (lat == 1) check(trig_lvl == 1'b0, "R8 level held", trig_lvl, 0);
    end
    check(lat == 5, "R8 run cleared", lat, 5);
    trig_raw = 1'b0;
    cyc(20);

    // R8: prescaler count clears on select change
    flt_code = 4'd0;
    psc_sel = 2'd2;
    cyc(20);
    l0 = trig_lvl;
    pulse();
    psc_sel = 2'd3;
    cyc(5);
    k = 0;
    while (trig_lvl === l0 && k < 20) begin
      pulse();
      k++;
    end
    check(k == 4, "R8 prescaler cleared", k, 4);
    cyc(10);

    // R9: rise pulse bookkeeping over the whole run
    check(rises_seen == lvl_rises, "R9 one pulse per rise", rises_seen, lvl_rises);
    check(wide_pulses == 0, "R9 single-cycle pulse", wide_pulses, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule